// File: doc/BRIEF.md
# Pad Ownership and Buffer Enable Multiplexer

This block decides who drives one I/O pad and what reaches the logic behind it. A stored 4-bit mode selects the owner. Mode 0 gives the pad to the GPIO controller. Modes 1 to 15 hand it to one of the native functions muxed onto the pad.

Under GPIO ownership, two disable bits switch the output and input buffers off, and a level bit sets the driven value. Under native ownership, the selected function supplies its output data and output enable. A 2-bit enable policy decides the input side. The input can follow the function's own enable, or it can be held off while a constant 0 or 1 is fed internally to the function. It can also be forced on.

Configuration is written through a single-cycle write strobe and held in registers. The pad controls themselves are combinational from those registers and the live function and pad inputs. A function slot with nothing attached, set by a presence mask, drives nothing and receives 0.

Top module: `pad_mux`

## Requirements
- R1: After reset the mode is 0, both GPIO buffer disables are 1 and the policy is 0, so pad_oe=0, pad_ie=0, gpio_rx=0 and fn_rx is all zero.
- R2: The configuration inputs are captured only on a rising clock edge with cfg_wr=1. With cfg_wr=0, changes on them leave every output unchanged.
- R3: In mode 0, pad_oe equals the inverse of the stored TX-disable bit and pad_out equals the stored TX level bit. The function inputs have no effect.
- R4: In mode 0, pad_ie equals the inverse of the stored RX-disable bit, and gpio_rx equals pad_in when the input is enabled and 0 otherwise.
- R5: In mode 0 the 2-bit enable policy has no effect on any output.
- R6: In a mode k from 1 to 15 whose function is present, pad_out equals fn_out[k-1] and pad_oe equals fn_oe[k-1]. The GPIO disable and level bits have no effect.
- R7: Native policy 0: pad_ie equals fn_ie[k-1], and fn_rx[k-1] equals pad_in when that enable is 1, else 0.
- R8: Native policy 1: pad_ie=0 and fn_rx[k-1]=0 regardless of pad_in.
- R9: Native policy 2: pad_ie=0 and fn_rx[k-1]=1 regardless of pad_in.
- R10: Native policy 3: pad_ie=1 and fn_rx[k-1] equals pad_in regardless of fn_ie.
- R11: At most one fn_rx bit is ever 1, and only the selected function's bit may be nonzero. gpio_rx is 0 in every non-zero mode.
- R12: A mode whose function is absent (presence mask bit k-1 is 0; by default function 15 is absent) gives pad_oe=0, pad_ie=0, pad_out=0 and fn_rx all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 4 | Owner: 0 GPIO, k native function k |
| cfg_policy | input | 2 | Native input enable policy |
| cfg_rx_dis | input | 1 | GPIO input buffer disable |
| cfg_tx_dis | input | 1 | GPIO output buffer disable |
| cfg_tx_lvl | input | 1 | GPIO output level |
| fn_out | input | 15 | Output data from each native function |
| fn_oe | input | 15 | Output enable from each native function |
| fn_ie | input | 15 | Input enable from each native function |
| pad_in | input | 1 | Value received from the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Output buffer enable (0 = high impedance) |
| pad_ie | output | 1 | Input buffer enable |
| fn_rx | output | 15 | Internal receive value for each native function |
| gpio_rx | output | 1 | Receive value for the GPIO controller |

## Verification
Several rules are checked on every cycle by assertions. These cover the one-hot receive fan-out and the silence of gpio_rx outside mode 0. They also cover what a write produces on the following cycle: the GPIO output controls, a disabled GPIO input, the forced-low and forced-high policies, and the all-quiet result for an absent function. Scenarios in the bench are needed for the rest. These include the reset state and config changes without a strobe. They also include fn_rx following live pad_in under policies 0 and 3, and the policy field and GPIO bits being ignored in the mode where they do not apply.

// File: rtl/pad_mux.sv
module pad_mux #(
  parameter int NFUNC = 15,
  parameter logic [NFUNC-1:0] FN_PRESENT = {1'b0, {(NFUNC-1){1'b1}}},
  parameter int MW = $clog2(NFUNC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [MW-1:0]    cfg_mode,
  input  logic [1:0]       cfg_policy,
  input  logic             cfg_rx_dis,
  input  logic             cfg_tx_dis,
  input  logic             cfg_tx_lvl,
  input  logic [NFUNC-1:0] fn_out,
  input  logic [NFUNC-1:0] fn_oe,
  input  logic [NFUNC-1:0] fn_ie,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_ie,
  output logic [NFUNC-1:0] fn_rx,
  output logic             gpio_rx
);

  logic [MW-1:0] mode_q;
  logic [1:0]    policy_q;
  logic          rx_dis_q, tx_dis_q, tx_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      policy_q <= 2'd0;
      rx_dis_q <= 1'b1;
      tx_dis_q <= 1'b1;
      tx_lvl_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q   <= cfg_mode;
      policy_q <= cfg_policy;
      rx_dis_q <= cfg_rx_dis;
      tx_dis_q <= cfg_tx_dis;
      tx_lvl_q <= cfg_tx_lvl;
    end
  end

  logic [NFUNC-1:0] sel;
  for (genvar k = 0; k < NFUNC; k++) begin : g_sel
    assign sel[k] = (mode_q == MW'(k + 1)) && FN_PRESENT[k];
  end

  wire gpio_own = (mode_q == '0);
  wire native   = |sel;
  wire f_out    = |(sel & fn_out);
  wire f_oe     = |(sel & fn_oe);
  wire f_ie     = |(sel & fn_ie);

  logic n_ie, n_forced, n_level;
  always_comb begin
    n_forced = 1'b0;
    n_level  = 1'b0;
    unique case (policy_q)
      2'd0: n_ie = f_ie;
      2'd1: begin n_ie = 1'b0; n_forced = 1'b1; end
      2'd2: begin n_ie = 1'b0; n_forced = 1'b1; n_level = 1'b1; end
      default: n_ie = 1'b1;
    endcase
  end

  wire rx_val = n_forced ? n_level : (n_ie & pad_in);

  assign pad_oe  = gpio_own ? !tx_dis_q : f_oe;
  assign pad_out = gpio_own ? tx_lvl_q : f_out;
  assign pad_ie  = gpio_own ? !rx_dis_q : (native & n_ie);
  assign fn_rx   = sel & {NFUNC{rx_val}};
  assign gpio_rx = gpio_own & !rx_dis_q & pad_in;

endmodule

module pad_mux_chk #(
  parameter int NFUNC = 15,
  parameter logic [NFUNC-1:0] FN_PRESENT = '1,
  parameter int MW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [MW-1:0]    cfg_mode,
  input logic [1:0]       cfg_policy,
  input logic             cfg_rx_dis,
  input logic             cfg_tx_dis,
  input logic             cfg_tx_lvl,
  input logic             pad_out,
  input logic             pad_oe,
  input logic             pad_ie,
  input logic [NFUNC-1:0] fn_rx,
  input logic             gpio_rx,
  input logic [MW-1:0]    mode_q
);

  function automatic logic present(input logic [MW-1:0] m);
    return (m != '0) && (int'(m) <= NFUNC) && FN_PRESENT[(int'(m) - 1) % NFUNC];
  endfunction

  p_gpio_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == '0) |=> (pad_oe == !$past(cfg_tx_dis) && pad_out == $past(cfg_tx_lvl)));

  p_gpio_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == '0 && cfg_rx_dis) |=> (!pad_ie && !gpio_rx));

  p_forced_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode != '0 && cfg_policy == 2'd1) |=> (!pad_ie && fn_rx == '0));

  p_forced_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && present(cfg_mode) && cfg_policy == 2'd2) |=> (!pad_ie && $countones(fn_rx) == 1));

  p_onehot_rx_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fn_rx));

  p_gpio_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != '0) |-> !gpio_rx);

  p_absent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode != '0 && !present(cfg_mode)) |=>
      (!pad_oe && !pad_ie && !pad_out && fn_rx == '0));

endmodule

bind pad_mux pad_mux_chk #(.NFUNC(NFUNC), .FN_PRESENT(FN_PRESENT), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_policy(cfg_policy),
  .cfg_rx_dis(cfg_rx_dis), .cfg_tx_dis(cfg_tx_dis), .cfg_tx_lvl(cfg_tx_lvl),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .fn_rx(fn_rx),
  .gpio_rx(gpio_rx), .mode_q(mode_q)
);

// File: tb/test_pad_mux.sv
module test_pad_mux;
  localparam int NF = 15;

  logic clk = 0, rst_n = 0, cfg_wr = 0;
  logic [3:0] cfg_mode = 0;
  logic [1:0] cfg_policy = 0;
  logic cfg_rx_dis = 1, cfg_tx_dis = 1, cfg_tx_lvl = 0;
  logic [NF-1:0] fn_out = 0, fn_oe = 0, fn_ie = 0;
  logic pad_in = 0;
  logic pad_out, pad_oe, pad_ie, gpio_rx;
  logic [NF-1:0] fn_rx;

  always #10 clk = ~clk;

  pad_mux i_pad_mux (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_policy(cfg_policy),
    .cfg_rx_dis(cfg_rx_dis), .cfg_tx_dis(cfg_tx_dis), .cfg_tx_lvl(cfg_tx_lvl),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_ie(fn_ie), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .fn_rx(fn_rx), .gpio_rx(gpio_rx)
  );

  typedef struct {
    logic out, oe, ie, grx;
    logic [NF-1:0] rx;
    string req;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  // model of stored configuration, per R1 and R2
  logic [3:0] m_mode = 0;
  logic [1:0] m_pol = 0;
  logic m_rxd = 1, m_txd = 1, m_lvl = 0;

  function automatic item_t model(string req);
    item_t e;
    int k = int'(m_mode);
    logic ie_n, rxv;
    e.req = req; e.rx = '0; e.grx = 0;
    if (k == 0) begin
      e.oe = !m_txd; e.out = m_lvl; e.ie = !m_rxd; e.grx = !m_rxd && pad_in;
    end else if (k == 15) begin
      e.oe = 0; e.out = 0; e.ie = 0;
    end else begin
      e.oe = fn_oe[k-1]; e.out = fn_out[k-1];
      case (m_pol)
        2'd0: begin ie_n = fn_ie[k-1]; rxv = ie_n && pad_in; end
        2'd1: begin ie_n = 0; rxv = 0; end
        2'd2: begin ie_n = 0; rxv = 1; end
        default: begin ie_n = 1; rxv = pad_in; end
      endcase
      e.ie = ie_n; e.rx[k-1] = rxv;
    end
    return e;
  endfunction

  task automatic apply(input bit wr, input logic [3:0] md, input logic [1:0] pol,
                       input logic rxd, input logic txd, input logic lvl,
                       input logic [NF-1:0] fo, input logic [NF-1:0] foe,
                       input logic [NF-1:0] fie, input logic pin, input string req);
    @(negedge clk);
    cfg_wr = wr; cfg_mode = md; cfg_policy = pol;
    cfg_rx_dis = rxd; cfg_tx_dis = txd; cfg_tx_lvl = lvl;
    @(negedge clk);
    cfg_wr = 0;
    if (wr) begin m_mode = md; m_pol = pol; m_rxd = rxd; m_txd = txd; m_lvl = lvl; end
    fn_out = fo; fn_oe = foe; fn_ie = fie; pad_in = pin;
    q.push_back(model(req));
    @(posedge clk); #5;
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        compared++;
        if ({pad_out, pad_oe, pad_ie, gpio_rx, fn_rx} != {e.out, e.oe, e.ie, e.grx, e.rx}) begin
          mismatched++;
          $display("FAIL %s: out/oe/ie/grx/rx actual %b%b%b%b %h expected %b%b%b%b %h",
                   e.req, pad_out, pad_oe, pad_ie, gpio_rx, fn_rx,
                   e.out, e.oe, e.ie, e.grx, e.rx);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, function inputs busy
    apply(0, 0, 0, 1, 1, 0, '1, '1, '1, 1, "R1");
    // R3 GPIO drives high, R4 input enabled
    apply(1, 0, 0, 0, 0, 1, '0, '0, '0, 1, "R3");
    apply(0, 0, 0, 0, 0, 1, '0, '0, '0, 0, "R4");
    // R2 config change without strobe ignored
    apply(0, 5, 3, 1, 1, 0, '0, '0, '0, 1, "R2");
    // R4 input disabled, R3 output off
    apply(1, 0, 0, 1, 1, 1, '1, '1, '1, 1, "R4");
    // R5 policy ignored in mode 0
    apply(1, 0, 2, 0, 0, 0, '1, '1, '1, 1, "R5");
    apply(1, 0, 1, 0, 0, 1, '0, '0, '0, 1, "R5");
    // R6 native function 3 drives, GPIO bits ignored
    apply(1, 3, 0, 0, 0, 0, 15'h0004, 15'h0004, 15'h0000, 1, "R6");
    apply(1, 3, 0, 1, 1, 1, 15'h7FFB, 15'h7FFB, 15'h0004, 1, "R6");
    // R7 policy 0 follows fn_ie
    apply(1, 7, 0, 1, 1, 0, '0, '0, 15'h0040, 1, "R7");
    apply(0, 7, 0, 1, 1, 0, '0, '0, 15'h0040, 0, "R7");
    apply(0, 7, 0, 1, 1, 0, '0, '0, 15'h7FBF, 1, "R7");
    // R8 forced low
    apply(1, 2, 1, 0, 0, 0, '1, '1, '1, 1, "R8");
    // R9 forced high
    apply(1, 2, 2, 0, 0, 0, '1, '0, '1, 0, "R9");
    apply(1, 14, 2, 0, 0, 0, '0, '0, '0, 0, "R9");
    // R10 always on
    apply(1, 1, 3, 0, 0, 0, '0, '0, '0, 1, "R10");
    apply(0, 1, 3, 0, 0, 0, '0, '0, '0, 0, "R10");
    // R11 native mode keeps gpio_rx quiet and one fn_rx bit
    apply(1, 9, 3, 0, 0, 0, '1, '1, '1, 1, "R11");
    // R12 absent function 15
    apply(1, 15, 3, 0, 0, 1, '1, '1, '1, 1, "R12");
    apply(1, 15, 2, 0, 0, 1, '1, '1, '1, 1, "R12");
    // R1 reset again mid-run
    @(negedge clk); rst_n = 0;
    m_mode = 0; m_pol = 0; m_rxd = 1; m_txd = 1; m_lvl = 0;
    @(negedge clk); rst_n = 1;
    apply(0, 0, 0, 0, 0, 1, '1, '1, '1, 1, "R1");
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule